// File: doc/BRIEF.md
# Bounded Uninterruptible Section Timer

This block lets unprivileged code protect a short run of instructions from interrupts without a call into the kernel. An enter strobe starts a protected section. Interrupt delivery is then masked and a cycle counter starts from zero. An exit strobe ends the section and unmasks delivery. Each strobe takes effect at the next clock edge, and code inside the section runs at full speed.

The counter is 8 bits wide by default, so a section may hold for at most 256 masked cycles. If the counter is at its maximum and the section has not ended, the block ends the section itself. It raises a one-cycle fatal fault for the current process and unmasks delivery. No request is lost while the section holds. Each request line that is seen high during a masked cycle sets its own sticky bit. Those bits reach the interrupt controller together in the first unmasked cycle, so the worst-case added latency is 256 cycles.

Top module: `solo_guard`

## Requirements
- R1: After synchronous active-low reset, masked_o and fault_o are 0, no request is held, and irq_out_o equals irq_req_i.
- R2: An enter strobe while unmasked raises masked_o at the next clock edge and restarts the budget counter at zero. While masked_o is 1, every bit of irq_out_o is 0.
- R3: An exit strobe while masked lowers masked_o at the next clock edge, and fault_o stays 0.
- R4: Counting the cycle after the enter edge as masked cycle 1, a section that reaches masked cycle 256 with no exit strobe in that cycle is ended at the next edge. In that cycle fault_o is 1 for exactly one cycle and masked_o is 0. An exit strobe in masked cycle 256 ends the section cleanly.
- R5: A request line that is 1 in any masked cycle, including the cycle that carries the exit strobe, is held. It appears on the same bit of irq_out_o in the first unmasked cycle, ORed with the live requests.
- R6: Held requests are cleared after that first unmasked cycle. From then on, irq_out_o equals irq_req_i in the same cycle.
- R7: An exit strobe while unmasked has no effect on masked_o, fault_o or irq_out_o.
- R8: An enter strobe while masked does not restart the counter, so the fault still arrives at the same cycle.
- R9: In the cycle in which fault_o is 1, irq_out_o carries every request held during the section, ORed with the live requests.
- R10: If enter and exit strobes arrive in the same cycle, the enter strobe wins while unmasked and the exit strobe wins while masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enter_i | input | 1 | Section-begin strobe |
| exit_i | input | 1 | Section-end strobe |
| irq_req_i | input | NUM_IRQ | Raw interrupt request lines |
| irq_out_o | output | NUM_IRQ | Requests delivered to the interrupt controller |
| masked_o | output | 1 | High while a protected section holds |
| fault_o | output | 1 | One-cycle pulse when the cycle budget runs out |

## Verification
Sections of short, medium and exactly maximal length, each closed by an exit strobe, separate a correct budget limit from one that is off by one cycle. Sections left to run out, with enter strobes repeated inside them, show whether the fault comes at the right cycle and whether a repeated enter wrongly restarts the count. Requests raised at the start, in the middle and in the exit or fault cycle of a section show whether they are held and delivered once. Simultaneous enter and exit strobes in both states, and lone exit strobes while unmasked, exercise the priority rules. These directed cases are mixed with a long stream of sparse random strobes and request bits.

// File: rtl/solo_guard_pkg.sv
// Package: shared defaults and the section state type for the guard.
// Assumes: nothing; it holds only types and constants.
package solo_guard_pkg;
    localparam int unsigned BUDGET_W_DEF = 8;
    localparam int unsigned NUM_IRQ_DEF  = 8;

    typedef enum logic {
        SEC_OPEN = 1'b0,
        SEC_HELD = 1'b1
    } sec_state_t;
endpackage

// File: rtl/solo_budget.sv
// Cycle budget counter. It restarts at zero when a section begins and
// advances once per clock while the section holds.
// Assumes: start_i is only asserted while run_i is low.
module solo_budget #(
    parameter int unsigned BUDGET_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic at_max_o
);
    localparam logic [BUDGET_W-1:0] LIMIT = {BUDGET_W{1'b1}};

    logic [BUDGET_W-1:0] cnt_q;

    // Restart on section begin, advance while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final budget cycle.
    always_comb begin
        at_max_o = (cnt_q == LIMIT);
    end

    // Section start zeroes the count.
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0));

    // Counting continues one step per held cycle; a repeated enter cannot reset it.
    p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/solo_ctrl.sv
// Section controller. It tracks open/held, applies the strobe priority
// rules and ends an over-long section with a one-cycle fault.
// Assumes: at_max_i is valid in every held cycle.
module solo_ctrl
    import solo_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic exit_i,
    input  logic at_max_i,
    output logic start_o,
    output logic held_o,
    output logic fault_o
);
    sec_state_t state_q;
    sec_state_t state_d;
    logic       fault_q;
    logic       fault_d;

    // Next-state and fault decision.
    always_comb begin
        state_d = state_q;
        fault_d = 1'b0;
        start_o = 1'b0;
        case (state_q)
            SEC_OPEN: begin
                if (enter_i) begin
                    state_d = SEC_HELD;
                    start_o = 1'b1;
                end
            end
            SEC_HELD: begin
                if (exit_i) begin
                    state_d = SEC_OPEN;
                end else if (at_max_i) begin
                    state_d = SEC_OPEN;
                    fault_d = 1'b1;
                end
            end
            default: state_d = SEC_OPEN;
        endcase
    end

    // State and fault registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEC_OPEN;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    // Drive outputs from the registers.
    always_comb begin
        held_o  = (state_q == SEC_HELD);
        fault_o = fault_q;
    end

    p_enter_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && enter_i) |=> held_o);

    p_exit_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && exit_i) |=> (!held_o && !fault_o));

    p_fault_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    p_fault_ends_section_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!held_o && $past(held_o)));

    p_idle_exit_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && !enter_i) |=> (!held_o && !fault_o));
endmodule

// File: rtl/solo_irq_hold.sv
// Request holding stage. Each line has a sticky bit that is set in held
// cycles and released in the first open cycle. Output is gated while held.
// Assumes: held_i comes from a register.
module solo_irq_hold #(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               held_i,
    input  logic [NUM_IRQ-1:0] req_i,
    output logic [NUM_IRQ-1:0] deliver_o
);
    logic [NUM_IRQ-1:0] pend_q;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        // Sticky capture while held, release once open.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (held_i) begin
                pend_q[g] <= pend_q[g] | req_i[g];
            end else begin
                pend_q[g] <= 1'b0;
            end
        end

        // Gate delivery during a held section.
        always_comb begin
            deliver_o[g] = !held_i && (req_i[g] | pend_q[g]);
        end

        p_captured_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (held_i && req_i[g]) |=> (pend_q[g] || !held_i && deliver_o[g]));

        p_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !held_i |=> !pend_q[g]);
    end
endmodule

// File: rtl/solo_guard.sv
// Bounded uninterruptible section timer (top). It ties together the
// section controller, the cycle budget and the request holding stage.
// Assumes: enter_i and exit_i are single-cycle strobes that are
// synchronous to clk.
module solo_guard #(
    parameter int unsigned NUM_IRQ  = solo_guard_pkg::NUM_IRQ_DEF,
    parameter int unsigned BUDGET_W = solo_guard_pkg::BUDGET_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter_i,
    input  logic               exit_i,
    input  logic [NUM_IRQ-1:0] irq_req_i,
    output logic [NUM_IRQ-1:0] irq_out_o,
    output logic               masked_o,
    output logic               fault_o
);
    logic start_w;
    logic held_w;
    logic at_max_w;

    solo_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter_i  (enter_i),
        .exit_i   (exit_i),
        .at_max_i (at_max_w),
        .start_o  (start_w),
        .held_o   (held_w),
        .fault_o  (fault_o)
    );

    solo_budget #(.BUDGET_W(BUDGET_W)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .run_i    (held_w),
        .at_max_o (at_max_w)
    );

    solo_irq_hold #(.NUM_IRQ(NUM_IRQ)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .held_i    (held_w),
        .req_i     (irq_req_i),
        .deliver_o (irq_out_o)
    );

    // Export the section flag.
    always_comb begin
        masked_o = held_w;
    end

    p_silent_when_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        masked_o |-> (irq_out_o == '0));

    p_both_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && exit_i) |=> (masked_o != $past(masked_o)));
endmodule

// File: tb/tb_solo_guard.sv
`timescale 1ns/1ps
module tb_solo_guard;
    localparam int N      = 8;
    localparam int BW     = 8;
    localparam int BLIMIT = (1 << BW) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enter = 1'b0;
    logic         exitp = 1'b0;
    logic [N-1:0] irq = '0;
    logic [N-1:0] irq_out;
    logic         masked;
    logic         fault;

    int checks = 0;
    int fails  = 0;

    // Reference state, kept from the requirements.
    logic         m_held = 1'b0;
    int           m_cnt  = 0;
    logic [N-1:0] m_pend = '0;
    logic         m_fault = 1'b0;

    always #2.5 clk = ~clk;

    solo_guard #(.NUM_IRQ(N), .BUDGET_W(BW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_i   (enter),
        .exit_i    (exitp),
        .irq_req_i (irq),
        .irq_out_o (irq_out),
        .masked_o  (masked),
        .fault_o   (fault)
    );

    function automatic logic [N-1:0] exp_deliver(input logic held, input logic [N-1:0] pend,
                                                 input logic [N-1:0] live);
        return held ? '0 : (live | pend);
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // One cycle: drive, check outputs, then advance the reference.
    task automatic step(input logic e, input logic x, input logic [N-1:0] q, input string tag);
        logic [N-1:0] exp_out;
        @(negedge clk);
        enter = e; exitp = x; irq = q;
        #1;
        exp_out = exp_deliver(m_held, m_pend, q);
        checks++;
        if (masked !== m_held || fault !== m_fault || irq_out !== exp_out) begin
            fails++;
            $display("FAIL %s: masked=%b fault=%b irq_out=%h expected masked=%b fault=%b irq_out=%h",
                     tag, masked, fault, irq_out, m_held, m_fault, exp_out);
        end
        @(posedge clk);
        m_fault = 1'b0;
        if (m_held) begin
            m_pend = m_pend | q;
            if (x) begin
                m_held = 1'b0;
            end else if (m_cnt == BLIMIT) begin
                m_held  = 1'b0;
                m_fault = 1'b1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end else begin
            m_pend = '0;
            if (e) begin
                m_held = 1'b1;
                m_cnt  = 0;
            end
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, requests pass through
        step(1'b0, 1'b0, 8'h5A, "R1");
        step(1'b0, 1'b0, 8'h00, "R1");

        // R7: exit while unmasked is inert
        step(1'b0, 1'b1, 8'h00, "R7");
        step(1'b0, 1'b1, 8'h03, "R7");
        step(1'b0, 1'b0, 8'h00, "R7");

        // R2, R3, R5, R6: short section with requests, including one in the exit cycle
        step(1'b1, 1'b0, 8'h00, "R2");
        step(1'b0, 1'b0, 8'h01, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'h10, "R5");
        step(1'b0, 1'b1, 8'h80, "R3");
        step(1'b0, 1'b0, 8'h00, "R5");
        step(1'b0, 1'b0, 8'h00, "R6");
        step(1'b0, 1'b0, 8'h22, "R6");

        // R4: exit in the last allowed cycle ends cleanly
        step(1'b1, 1'b0, 8'h00, "R4");
        for (int i = 0; i < BLIMIT; i++) step(1'b0, 1'b0, 8'h00, "R4");
        step(1'b0, 1'b1, 8'h04, "R4");
        step(1'b0, 1'b0, 8'h00, "R4");
        step(1'b0, 1'b0, 8'h00, "R4");

        // R8, R9: overrun with repeated enters and held requests
        step(1'b1, 1'b0, 8'h00, "R8");
        for (int i = 0; i <= BLIMIT; i++) begin
            step((i % 50) == 7, 1'b0, (i == 3) ? 8'h40 : ((i == BLIMIT) ? 8'h02 : 8'h00), "R8");
        end
        step(1'b0, 1'b0, 8'h08, "R9");
        step(1'b0, 1'b0, 8'h00, "R9");

        // R10: simultaneous strobes in both states
        step(1'b1, 1'b1, 8'h00, "R10");
        step(1'b0, 1'b0, 8'h20, "R10");
        step(1'b1, 1'b1, 8'h00, "R10");
        step(1'b0, 1'b0, 8'h00, "R10");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic         re;
            logic         rx;
            logic [N-1:0] rq;
            re = (($urandom % 8) == 0);
            rx = (($urandom % 100) == 0);
            rq = N'($urandom) & N'($urandom) & N'($urandom);
            step(re, rx, rq, "R5");
        end

        summary();
        $finish;
    end
endmodule